// File: doc/BRIEF.md
# Quasi-Resonant Gate Timing Controller

This block sequences the on and off phases of the power-switch gate in a flyback converter that switches in the valleys of the drain ringing. All analog comparisons happen outside the block. It receives a one-cycle pulse for each falling zero crossing, a level flag from the zero-crossing comparator, and two current-sense flags: one set when the sensed current exceeds the feedback level and one set when it exceeds the current limit. The block decides when the gate rises and when it falls. All durations are cycle counts taken from register inputs.

After the gate falls, a ringing-suppression window keeps it low. The window length is one of two presets, selected by the zero-crossing level flag at the moment of turn-off. Once the window ends, the gate rises when enough zero crossings have been counted. If the gate has been off for the maximum off time, it rises without the count. Once the gate rises, the current-sense flags are ignored for a blanking interval. After that, either flag ends the pulse. A current-limit hit removes the gate in the same cycle. A maximum on time ends any pulse that runs too long. The block records one cause code for each turn-off.

Top module: `qr_gate_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `gate` is 0, `zc_count` is 0, `off_cause` is 0, `off_event` is 0 and `phase[1]` is 0.
- R2: After every falling edge of `gate`, the gate stays low for at least the selected suppression length in cycles. While `phase` is 2'b00 (suppression active), the gate cannot rise at the next edge.
- R3: The suppression length is selected by `zc_high` at the turn-off edge, or at reset. A value of 1 selects `t_rs_short` and a value of 0 selects `t_rs_long`.
- R4: Once the gate has been low for at least the suppression length and `zc_count >= zc_target`, the gate rises at the next edge.
- R5: Once suppression has ended and the gate has been low for `t_off_max` cycles, the gate rises at the next edge, whatever the count and the level flag.
- R6: `zc_count` increments on each `zc_pulse` while the gate is off and saturates at all ones. It clears when the gate turns on and stays 0 while the gate is on.
- R7: During the first `t_blank` on-cycles less one, both current-sense flags are ignored. `phase` is 2'b10 while blanking and 2'b11 after blanking; in off time, 2'b01 means suppression has ended.
- R8: After blanking, `cs_over_fb` high in a cycle makes `gate` low from the next cycle on.
- R9: After blanking, `cs_over_lim` high forces `gate` low in the same cycle, and the gate stays low from then on.
- R10: `gate` is never high for more than `t_on_max` consecutive cycles (with `t_on_max` of 0 acting as 1).
- R11: Each turn-off raises `off_event` for exactly the first off cycle. The same edge loads `off_cause`, which holds until the next turn-off. The codes are 1 for feedback, 2 for current limit and 3 for maximum on time, and a limit hit takes priority over a feedback hit, which takes priority over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_pulse | input | 1 | One-cycle pulse per falling zero crossing |
| zc_high | input | 1 | Zero-crossing pin at or above the suppression threshold |
| cs_over_fb | input | 1 | Sensed current above the feedback level |
| cs_over_lim | input | 1 | Sensed current above the current limit |
| zc_target | input | ZW | Zero crossings required for turn-on |
| t_blank | input | TW | Leading-edge blanking length (cycles) |
| t_rs_short | input | TW | Suppression length when the level is high |
| t_rs_long | input | TW | Suppression length when the level is low |
| t_on_max | input | TW | Maximum on time (cycles) |
| t_off_max | input | TW | Maximum off time (cycles) |
| gate | output | 1 | Gate drive |
| phase | output | 2 | {gate on, window ended} |
| zc_count | output | ZW | Zero crossings counted in this off period |
| off_cause | output | 2 | Cause of the last turn-off |
| off_event | output | 1 | First cycle after a turn-off |

## Verification
The bench exercises the controller under several regimes. Dense zero-crossing pulses with occasional feedback trips show turn-on by count and turn-off by feedback. Mixed limit and feedback trips, some of them inside blanking, check the same-cycle limit kill and the cause priority. Silent comparators with no pulses force both the maximum on time and the maximum off time fallback. Runs with zero lengths, a zero target and a saturating target count probe the boundaries. A toggling level flag tells the short suppression preset apart from the long one.

// File: rtl/qr_pkg.sv
package qr_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_FB    = 2'd1,
        CAUSE_LIM   = 2'd2,
        CAUSE_MAXON = 2'd3
    } off_cause_e;

    typedef struct packed {
        logic on;
        logic window_done;
    } phase_t;

    typedef struct packed {
        logic       fire;
        off_cause_e cause;
    } off_dec_t;

    function automatic off_cause_e pick_cause(input logic lim, input logic fb);
        if (lim)     return CAUSE_LIM;
        else if (fb) return CAUSE_FB;
        else         return CAUSE_MAXON;
    endfunction

endpackage

// File: rtl/qr_phase_timer.sv
module qr_phase_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [TW-1:0] elapsed
);
    localparam logic [TW-1:0] SAT = {TW{1'b1}};
    localparam logic [TW-1:0] ONE = TW'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)       elapsed <= ONE;
        else if (elapsed != SAT) elapsed <= elapsed + ONE;
    end

    AST_TMR_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !clr |=> elapsed >= $past(elapsed)); // R10

endmodule

// File: rtl/qr_zc_counter.sv
module qr_zc_counter #(
    parameter int ZW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [ZW-1:0] count
);
    localparam logic [ZW-1:0] SAT = {ZW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)              count <= '0;
        else if (inc && count != SAT) count <= count + ZW'(1);
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (count == SAT && !clr) |=> count == SAT); // R6

endmodule

// File: rtl/qr_on_arbiter.sv
module qr_on_arbiter #(
    parameter int TW = 16,
    parameter int ZW = 4
) (
    input  logic [TW-1:0] elapsed,
    input  logic [TW-1:0] rs_len,
    input  logic [TW-1:0] t_off_max,
    input  logic [ZW-1:0] count,
    input  logic [ZW-1:0] target,
    output logic          rs_done,
    output logic          turn_on
);
    logic enough_zc;
    logic off_timeout;

    always_comb begin
        rs_done     = elapsed >= rs_len;
        enough_zc   = count >= target;
        off_timeout = elapsed >= t_off_max;
        turn_on     = rs_done && (enough_zc || off_timeout);
    end

endmodule

// File: rtl/qr_off_arbiter.sv
module qr_off_arbiter
    import qr_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          on,
    input  logic [TW-1:0] elapsed,
    input  logic [TW-1:0] t_blank,
    input  logic [TW-1:0] t_on_max,
    input  logic          fb,
    input  logic          lim,
    output logic          blank_done,
    output logic          lim_kill,
    output off_dec_t      dec
);
    logic lim_hit;
    logic fb_hit;
    logic max_hit;

    always_comb begin
        blank_done = elapsed >= t_blank;
        lim_hit    = blank_done && lim;
        fb_hit     = blank_done && fb;
        max_hit    = elapsed >= t_on_max;
        lim_kill   = on && lim_hit;
        dec.fire   = on && (lim_hit || fb_hit || max_hit);
        dec.cause  = pick_cause(lim_hit, fb_hit);
    end

endmodule

// File: rtl/qr_gate_ctrl.sv
module qr_gate_ctrl
    import qr_pkg::*;
#(
    parameter int TW = 16,
    parameter int ZW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          zc_pulse,
    input  logic          zc_high,
    input  logic          cs_over_fb,
    input  logic          cs_over_lim,
    input  logic [ZW-1:0] zc_target,
    input  logic [TW-1:0] t_blank,
    input  logic [TW-1:0] t_rs_short,
    input  logic [TW-1:0] t_rs_long,
    input  logic [TW-1:0] t_on_max,
    input  logic [TW-1:0] t_off_max,
    output logic          gate,
    output logic [1:0]    phase,
    output logic [ZW-1:0] zc_count,
    output logic [1:0]    off_cause,
    output logic          off_event
);
    logic          on_q;
    logic          rs_long_q;
    off_cause_e    cause_q;
    logic          evt_q;
    logic [TW-1:0] elapsed;
    logic [TW-1:0] rs_len;
    logic          rs_done;
    logic          turn_on;
    logic          blank_done;
    logic          lim_kill;
    off_dec_t      dec;
    logic          go_on;
    logic          go_off;
    phase_t        ph;

    assign rs_len = rs_long_q ? t_rs_long : t_rs_short;
    assign go_on  = !on_q && turn_on;
    assign go_off = on_q && dec.fire;

    qr_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (go_on || go_off),
        .elapsed (elapsed)
    );

    qr_zc_counter #(.ZW(ZW)) u_zc (
        .clk   (clk),
        .rst   (rst),
        .clr   (go_on || on_q),
        .inc   (zc_pulse && !on_q),
        .count (zc_count)
    );

    qr_on_arbiter #(.TW(TW), .ZW(ZW)) u_on_arb (
        .elapsed   (elapsed),
        .rs_len    (rs_len),
        .t_off_max (t_off_max),
        .count     (zc_count),
        .target    (zc_target),
        .rs_done   (rs_done),
        .turn_on   (turn_on)
    );

    qr_off_arbiter #(.TW(TW)) u_off_arb (
        .on         (on_q),
        .elapsed    (elapsed),
        .t_blank    (t_blank),
        .t_on_max   (t_on_max),
        .fb         (cs_over_fb),
        .lim        (cs_over_lim),
        .blank_done (blank_done),
        .lim_kill   (lim_kill),
        .dec        (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q      <= 1'b0;
            rs_long_q <= !zc_high;
            cause_q   <= CAUSE_NONE;
            evt_q     <= 1'b0;
        end else begin
            evt_q <= go_off;
            if (go_on) begin
                on_q <= 1'b1;
            end else if (go_off) begin
                on_q      <= 1'b0;
                rs_long_q <= !zc_high;
                cause_q   <= dec.cause;
            end
        end
    end

    always_comb begin
        ph.on          = on_q;
        ph.window_done = on_q ? blank_done : rs_done;
    end

    assign gate      = on_q && !lim_kill;
    assign phase     = ph;
    assign off_cause = cause_q;
    assign off_event = evt_q;

    AST_NO_ON_IN_RS: assert property (@(posedge clk) disable iff (rst)
        (!on_q && !rs_done) |=> !on_q); // R2
    AST_MIN_ON: assert property (@(posedge clk) disable iff (rst)
        (on_q && !blank_done && !(elapsed >= t_on_max)) |=> on_q); // R7
    AST_LIM_KILL: assert property (@(posedge clk) disable iff (rst)
        (on_q && blank_done && cs_over_lim) |-> !gate); // R9
    AST_CNT_ZERO_ON: assert property (@(posedge clk) disable iff (rst)
        on_q |-> zc_count == '0); // R6
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (rst)
        off_event |=> !off_event); // R11
    AST_EVT_OFF: assert property (@(posedge clk) disable iff (rst)
        off_event |-> !on_q); // R11

endmodule

// File: tb/test_qr_gate_ctrl.sv
module test_qr_gate_ctrl;
    localparam int CLK_P = 10;
    localparam int TW = 16;
    localparam int ZW = 4;
    localparam int TSAT = (1 << TW) - 1;
    localparam int ZSAT = (1 << ZW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic zc_pulse = 0, zc_high = 0, cs_over_fb = 0, cs_over_lim = 0;
    logic [ZW-1:0] zc_target = 2;
    logic [TW-1:0] t_blank = 4, t_rs_short = 3, t_rs_long = 8, t_on_max = 40, t_off_max = 200;
    logic gate, off_event;
    logic [1:0] phase, off_cause;
    logic [ZW-1:0] zc_count;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    qr_gate_ctrl #(.TW(TW), .ZW(ZW)) i_qr_gate_ctrl (
        .clk(clk), .rst(rst), .zc_pulse(zc_pulse), .zc_high(zc_high),
        .cs_over_fb(cs_over_fb), .cs_over_lim(cs_over_lim), .zc_target(zc_target),
        .t_blank(t_blank), .t_rs_short(t_rs_short), .t_rs_long(t_rs_long),
        .t_on_max(t_on_max), .t_off_max(t_off_max),
        .gate(gate), .phase(phase), .zc_count(zc_count),
        .off_cause(off_cause), .off_event(off_event)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    // behavioural reference: el = cycles spent in current phase including this one
    bit m_valid = 0;
    bit m_on;
    int m_el, m_cnt, m_cause;
    bit m_rslong, m_evt;

    always @(negedge clk) begin
        int rsl, e_gate, e_phase;
        bit bd, lim, fb, mx, rsd, ton;
        if (m_valid) begin
            rsl = m_rslong ? int'(t_rs_long) : int'(t_rs_short);
            rsd = m_el >= rsl;
            bd  = m_el >= int'(t_blank);
            e_gate  = (m_on && !(bd && cs_over_lim)) ? 1 : 0;
            e_phase = m_on ? (2 + (bd ? 1 : 0)) : (rsd ? 1 : 0);
            chk(gate == e_gate, "gate R2 R3 R4 R5 R8 R9 R10", gate, e_gate);
            chk(phase == e_phase, "phase R7", phase, e_phase);
            chk(zc_count == m_cnt, "zc_count R6", zc_count, m_cnt);
            chk(off_cause == m_cause, "off_cause R11", off_cause, m_cause);
            chk(off_event == m_evt, "off_event R11", off_event, m_evt);
        end
        if (rst) begin
            m_valid = 1; m_on = 0; m_el = 1; m_cnt = 0;
            m_rslong = !zc_high; m_cause = 0; m_evt = 0;
        end else if (m_valid) begin
            rsl = m_rslong ? int'(t_rs_long) : int'(t_rs_short);
            m_evt = 0;
            if (!m_on) begin
                ton = (m_el >= rsl) && (m_cnt >= int'(zc_target) || m_el >= int'(t_off_max));
                if (ton) begin
                    m_on = 1; m_el = 1; m_cnt = 0;
                end else begin
                    if (m_el < TSAT) m_el++;
                    if (zc_pulse && m_cnt < ZSAT) m_cnt++;
                end
            end else begin
                bd  = m_el >= int'(t_blank);
                lim = bd && cs_over_lim;
                fb  = bd && cs_over_fb;
                mx  = m_el >= int'(t_on_max);
                if (lim || fb || mx) begin
                    m_on = 0; m_el = 1; m_evt = 1;
                    m_rslong = !zc_high;
                    m_cause = lim ? 2 : (fb ? 1 : 3);
                end else if (m_el < TSAT) m_el++;
            end
        end
    end

    function automatic logic hit(input int n);
        return (n > 0) && ($urandom_range(n - 1) == 0);
    endfunction

    task automatic drive(input int cycles, input int p_zc, input int p_fb,
                         input int p_lim, input int hi_mode);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            zc_pulse    = hit(p_zc);
            cs_over_fb  = hit(p_fb);
            cs_over_lim = hit(p_lim);
            zc_high     = (hi_mode == 2) ? hit(2) : (hi_mode == 1);
        end
    endtask

    initial begin
        void'($urandom(7));
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(gate == 0, "R1 gate after reset", gate, 0);
        chk(zc_count == 0, "R1 zc_count after reset", zc_count, 0);
        chk(off_cause == 0, "R1 off_cause after reset", off_cause, 0);
        chk(off_event == 0, "R1 off_event after reset", off_event, 0);
        chk(phase[1] == 0, "R1 phase after reset", phase[1], 0);
        // count-driven turn-on, feedback turn-off, toggling level (R3 R4 R8)
        drive(800, 3, 8, 0, 2);
        // limit and feedback mixes, many inside blanking (R9 R11)
        drive(800, 2, 10, 10, 2);
        // timeouts only: no pulses, no comparators (R5 R10)
        t_on_max = 20; t_off_max = 60;
        drive(500, 0, 0, 0, 0);
        drive(300, 0, 0, 0, 1);
        // zero lengths and zero target
        t_blank = 0; t_rs_short = 0; t_rs_long = 0; zc_target = 0;
        drive(300, 4, 6, 9, 2);
        // saturating count with top target (R6)
        t_blank = 3; t_rs_short = 2; t_rs_long = 5; zc_target = ZSAT[ZW-1:0];
        t_on_max = 12; t_off_max = 400;
        drive(500, 1, 0, 0, 2);
        drive(400, 5, 20, 30, 2);
        // reset in mid-operation (R1)
        @(posedge clk); #1 rst = 1;
        @(posedge clk); #1 rst = 0;
        @(negedge clk);
        chk(gate == 0, "R1 gate after mid reset", gate, 0);
        chk(zc_count == 0, "R1 zc_count after mid reset", zc_count, 0);
        zc_target = 1; t_on_max = 30; t_off_max = 90;
        drive(400, 6, 12, 15, 2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule